// File: doc/BRIEF.md
# Per-Page Reactive Protocol Selector

This block sits on one node of a distributed shared-memory machine. It decides, for every remote page the node tracks, whether the page is served by fine-grained caching in the remote block cache or by whole-page caching in local main memory. Every page starts in block-cache mode. The block watches the miss stream of the remote block cache. It counts only the misses that show the block cache is too small for the page: capacity misses and conflict misses. When a page's count reaches a threshold that software programs, the block asks for that page to be relocated into local memory.

Miss events arrive on a valid/ready stream. The block never applies back-pressure: `miss_ready` is high in every cycle after reset, so the cache may issue one miss in each cycle. Relocation requests leave on a second valid/ready stream. A request stays valid, with a stable page index, until the consumer raises `reloc_ready`. A transfer happens at any rising edge where both signals are high. The consumer may hold `reloc_ready` low for as long as it needs.

A software eviction command moves a page back to block-cache mode. A combinational lookup port reports the mode each page has. All state belongs to this node alone.

Top module: `page_mode_selector`

## Requirements
- R1: After reset, every page reads block-cache mode (`lookup_mode` = 0) and `reloc_valid` is low.
- R2: A miss with class capacity (1) or conflict (2) adds one to the page's counter. While the counter is below the threshold, no request is raised.
- R3: Misses with class cold (0) or coherence (3) leave the counter unchanged.
- R4: When a block-mode page's counter is at or above a non-zero threshold and no request is outstanding, the block raises `reloc_valid` with `reloc_page` set to that page, two clock edges after the miss that reached the count.
- R5: An outstanding request holds `reloc_valid` and `reloc_page` steady until it is accepted. Misses to the requested page in that time do not change its counter.
- R6: When a request is accepted, that page switches to page-cache mode (`lookup_mode` = 1) and its counter is cleared.
- R7: Misses to a page in page-cache mode have no effect.
- R8: An eviction command returns the page to block-cache mode and clears its counter. If an eviction and an acceptance name the same page in the same cycle, the eviction wins.
- R9: When several pages are eligible, requests go out one at a time, lowest page index first.
- R10: A threshold of zero stops any new request from being raised.
- R11: `lookup_mode` shows the registered mode. An update made at a clock edge is seen only after that edge.
- R12: Counters saturate at their maximum value and never wrap.
- R13: `miss_ready` is high in every cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| miss_valid | input | 1 | A miss event is present |
| miss_ready | output | 1 | Block accepts miss events (always high) |
| miss_page | input | PAGE_W | Page index of the miss |
| miss_class | input | 2 | 0 cold, 1 capacity, 2 conflict, 3 coherence |
| thresh | input | CNT_W | Switching threshold; 0 disables switching |
| reloc_valid | output | 1 | A relocation request is pending |
| reloc_ready | input | 1 | Consumer accepts the request |
| reloc_page | output | PAGE_W | Page to relocate |
| evict_valid | input | 1 | Command to return a page to block-cache mode |
| evict_page | input | PAGE_W | Page for the eviction command |
| lookup_page | input | PAGE_W | Page whose mode is queried |
| lookup_mode | output | 1 | 0 block-cache mode, 1 page-cache mode |

## Verification
The bench builds the block with eight pages and a 4-bit counter. The saturation limit is then 15, and twenty misses push a counter well past it: a wrapping counter would hold 4 instead. Eight pages also let three pages become eligible behind one held request, so the bench can observe the lowest-index-first order. Same-cycle collisions between an eviction and an acceptance, and between a lookup and an update, are driven on purpose.

// File: rtl/pms_pkg.sv
package pms_pkg;

  typedef enum logic [1:0] {
    MC_COLD      = 2'd0,
    MC_CAPACITY  = 2'd1,
    MC_CONFLICT  = 2'd2,
    MC_COHERENCE = 2'd3
  } miss_class_e;

  // Only misses that show the block cache is too small count toward switching.
  function automatic logic class_counts(input logic [1:0] cls);
    return (cls == MC_CAPACITY) || (cls == MC_CONFLICT);
  endfunction

endpackage

// File: rtl/pms_page_slot.sv
module pms_page_slot #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit_miss,   // counted-class miss to this page
  input  logic             pending,    // this page holds the outstanding request
  input  logic             set_page,   // request for this page accepted
  input  logic             clr_block,  // eviction command to this page
  input  logic [CNT_W-1:0] thresh,
  output logic             mode,
  output logic             eligible
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      cnt_q  <= '0;
    end else if (clr_block) begin
      mode_q <= 1'b0;
      cnt_q  <= '0;
    end else if (set_page) begin
      mode_q <= 1'b1;
      cnt_q  <= '0;
    end else if (hit_miss && !mode_q && !pending && (cnt_q != CNT_MAX)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign mode     = mode_q;
  assign eligible = !mode_q && !pending && (thresh != '0) && (cnt_q >= thresh);

endmodule

// File: rtl/pms_pick.sv
module pms_pick #(
  parameter int N      = 8,
  parameter int IDX_W  = 3
) (
  input  logic [N-1:0]     eligible,
  output logic             any,
  output logic [IDX_W-1:0] idx
);

  // Lowest index wins: scan downward so the last assignment is the lowest.
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (eligible[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/pms_reloc_req.sv
module pms_reloc_req #(
  parameter int PAGE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cand_any,
  input  logic [PAGE_W-1:0] cand_idx,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [PAGE_W-1:0] out_page,
  output logic              fire
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_page  <= '0;
    end else if (!out_valid) begin
      if (cand_any) begin
        out_valid <= 1'b1;
        out_page  <= cand_idx;
      end
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign fire = out_valid && out_ready;

endmodule

// File: rtl/page_mode_selector.sv
module page_mode_selector #(
  parameter int NUM_PAGES = 16,
  parameter int CNT_W     = 6,
  localparam int PAGE_W   = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid,
  output logic              miss_ready,
  input  logic [PAGE_W-1:0] miss_page,
  input  logic [1:0]        miss_class,
  input  logic [CNT_W-1:0]  thresh,
  output logic              reloc_valid,
  input  logic              reloc_ready,
  output logic [PAGE_W-1:0] reloc_page,
  input  logic              evict_valid,
  input  logic [PAGE_W-1:0] evict_page,
  input  logic [PAGE_W-1:0] lookup_page,
  output logic              lookup_mode
);

  import pms_pkg::*;

  logic [NUM_PAGES-1:0] mode_q;
  logic [NUM_PAGES-1:0] elig;
  logic                 cand_any;
  logic [PAGE_W-1:0]    cand_idx;
  logic                 fire;
  logic                 miss_counts;

  assign miss_counts = miss_valid && class_counts(miss_class);

  for (genvar g = 0; g < NUM_PAGES; g++) begin : g_slot
    logic hit, pend, setp, clrp;
    assign hit  = miss_counts && (miss_page == PAGE_W'(g));
    assign pend = reloc_valid && (reloc_page == PAGE_W'(g));
    assign setp = fire && (reloc_page == PAGE_W'(g));
    assign clrp = evict_valid && (evict_page == PAGE_W'(g));

    pms_page_slot #(.CNT_W(CNT_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .hit_miss  (hit),
      .pending   (pend),
      .set_page  (setp),
      .clr_block (clrp),
      .thresh    (thresh),
      .mode      (mode_q[g]),
      .eligible  (elig[g])
    );
  end

  pms_pick #(.N(NUM_PAGES), .IDX_W(PAGE_W)) u_pick (
    .eligible (elig),
    .any      (cand_any),
    .idx      (cand_idx)
  );

  pms_reloc_req #(.PAGE_W(PAGE_W)) u_req (
    .clk       (clk),
    .rst_n     (rst_n),
    .cand_any  (cand_any),
    .cand_idx  (cand_idx),
    .out_ready (reloc_ready),
    .out_valid (reloc_valid),
    .out_page  (reloc_page),
    .fire      (fire)
  );

  assign miss_ready  = rst_n;
  assign lookup_mode = (int'(lookup_page) < NUM_PAGES) ? mode_q[lookup_page] : 1'b0;

endmodule

// File: rtl/pms_checker.sv
module pms_checker #(
  parameter int NUM_PAGES = 16,
  parameter int CNT_W     = 6,
  parameter int PAGE_W    = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [CNT_W-1:0]     thresh,
  input logic                 reloc_valid,
  input logic                 reloc_ready,
  input logic [PAGE_W-1:0]    reloc_page,
  input logic                 evict_valid,
  input logic [PAGE_W-1:0]    evict_page,
  input logic [NUM_PAGES-1:0] mode_q
);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reloc_valid && !reloc_ready) |=> (reloc_valid && $stable(reloc_page)));

  p_req_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reloc_valid |-> !mode_q[reloc_page]);

  p_accept_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reloc_valid && reloc_ready && !(evict_valid && evict_page == reloc_page))
      |=> mode_q[$past(reloc_page)]);

  p_evict_r8: assert property (@(posedge clk) disable iff (!rst_n)
    evict_valid |=> !mode_q[$past(evict_page)]);

  p_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (thresh == '0 && !reloc_valid) |=> !reloc_valid);

endmodule

bind page_mode_selector pms_checker #(
  .NUM_PAGES (NUM_PAGES),
  .CNT_W     (CNT_W),
  .PAGE_W    (PAGE_W)
) u_pms_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .thresh      (thresh),
  .reloc_valid (reloc_valid),
  .reloc_ready (reloc_ready),
  .reloc_page  (reloc_page),
  .evict_valid (evict_valid),
  .evict_page  (evict_page),
  .mode_q      (mode_q)
);

// File: tb/test_page_mode_selector.sv
module test_page_mode_selector;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 8;
  localparam int CW = 4;
  localparam int PW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          miss_valid = 1'b0;
  logic          miss_ready;
  logic [PW-1:0] miss_page = '0;
  logic [1:0]    miss_class = 2'd0;
  logic [CW-1:0] thresh = 4'd3;
  logic          reloc_valid;
  logic          reloc_ready = 1'b0;
  logic [PW-1:0] reloc_page;
  logic          evict_valid = 1'b0;
  logic [PW-1:0] evict_page = '0;
  logic [PW-1:0] lookup_page = '0;
  logic          lookup_mode;

  int n_run = 0;
  int n_fail = 0;
  int exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  page_mode_selector #(.NUM_PAGES(NP), .CNT_W(CW)) i_page_mode_selector (
    .clk(clk), .rst_n(rst_n),
    .miss_valid(miss_valid), .miss_ready(miss_ready),
    .miss_page(miss_page), .miss_class(miss_class),
    .thresh(thresh),
    .reloc_valid(reloc_valid), .reloc_ready(reloc_ready), .reloc_page(reloc_page),
    .evict_valid(evict_valid), .evict_page(evict_page),
    .lookup_page(lookup_page), .lookup_mode(lookup_mode)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic miss(input int p, input int c, input int n);
    for (int i = 0; i < n; i++) begin
      miss_valid = 1'b1;
      miss_page  = PW'(p);
      miss_class = 2'(c);
      step();
    end
    miss_valid = 1'b0;
  endtask

  task automatic mode_of(input int p, output int m);
    lookup_page = PW'(p);
    #1;
    m = lookup_mode;
  endtask

  // Scoreboard monitor: each accepted request must match the next expected page.
  always @(negedge clk) begin
    if (rst_n && reloc_valid && reloc_ready) begin
      n_run++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R9 unexpected request actual=%0d expected=none", reloc_page);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (int'(reloc_page) != e) begin
          n_fail++;
          $display("FAIL R9 request order actual=%0d expected=%0d", reloc_page, e);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int m;
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R1 reset state, R13 ready
    for (int p = 0; p < NP; p++) begin
      mode_of(p, m);
      check("R1 mode after reset", m, 0);
    end
    check("R1 no request", reloc_valid, 0);
    check("R13 miss_ready", miss_ready, 1);

    // R3 cold and coherence misses ignored
    miss(1, 0, 5);
    miss(1, 3, 5);
    step();
    check("R3 no count from cold/coherence", reloc_valid, 0);

    // R2 below threshold
    miss(1, 1, 2);
    step();
    check("R2 below threshold", reloc_valid, 0);

    // R4 reach threshold with a conflict miss
    miss(1, 2, 1);
    check("R4 not yet (pipeline)", reloc_valid, 0);
    step();
    check("R4 request raised", reloc_valid, 1);
    check("R4 request page", reloc_page, 1);

    // R5 hold while not ready, misses to pending page ignored
    miss(1, 1, 4);
    step();
    check("R5 still valid", reloc_valid, 1);
    check("R5 page stable", reloc_page, 1);

    // R6 accept; R11 lookup sees old mode in accept cycle
    exp_q.push_back(1);
    reloc_ready = 1'b1;
    mode_of(1, m);
    check("R11 mode before accept edge", m, 0);
    step();
    reloc_ready = 1'b0;
    mode_of(1, m);
    check("R6 page-cache mode", m, 1);
    step();
    check("R6 no further request", reloc_valid, 0);

    // R7 misses to page-cache page ignored
    miss(1, 1, 6);
    step();
    check("R7 no request", reloc_valid, 0);
    mode_of(1, m);
    check("R7 mode kept", m, 1);

    // R8 evict page 1; R11 lookup in same cycle shows old mode
    evict_valid = 1'b1;
    evict_page  = 3'd1;
    mode_of(1, m);
    check("R11 mode before evict edge", m, 1);
    step();
    evict_valid = 1'b0;
    mode_of(1, m);
    check("R8 back to block mode", m, 0);

    // R8 evict clears counter of a block-mode page
    miss(6, 1, 2);
    evict_valid = 1'b1;
    evict_page  = 3'd6;
    step();
    evict_valid = 1'b0;
    miss(6, 1, 2);
    step();
    check("R8 counter cleared by evict", reloc_valid, 0);
    miss(6, 1, 1);
    step();
    check("R8 third miss raises", reloc_valid, 1);
    check("R8 page 6", reloc_page, 6);
    exp_q.push_back(6);
    reloc_ready = 1'b1;
    step();
    reloc_ready = 1'b0;
    step();

    // R9 priority: page 4 pending, then 6? page 6 is now page mode; use 5 and 3
    miss(4, 1, 3);
    step();
    check("R9 first request page 4", reloc_page, 4);
    miss(5, 2, 3);
    miss(3, 1, 3);
    step();
    check("R9 page 4 still held", reloc_page, 4);
    exp_q.push_back(4);
    exp_q.push_back(3);
    exp_q.push_back(5);
    reloc_ready = 1'b1;
    for (int i = 0; i < 20 && exp_q.size() != 0; i++) step();
    reloc_ready = 1'b0;
    step();
    check("R9 all delivered", exp_q.size(), 0);

    // R10 threshold zero; R12 saturation
    thresh = 4'd0;
    miss(2, 1, 20);
    step();
    step();
    check("R10 zero threshold no request", reloc_valid, 0);
    thresh = 4'd15;
    step();
    step();
    check("R12 saturated count reaches 15", reloc_valid, 1);
    check("R12 page 2", reloc_page, 2);
    exp_q.push_back(2);
    reloc_ready = 1'b1;
    step();
    reloc_ready = 1'b0;
    thresh = 4'd3;

    // R8 evict and accept same page same cycle: evict wins
    miss(7, 1, 3);
    step();
    check("R4 page 7 request", reloc_page, 7);
    exp_q.push_back(7);
    reloc_ready = 1'b1;
    evict_valid = 1'b1;
    evict_page  = 3'd7;
    step();
    reloc_ready = 1'b0;
    evict_valid = 1'b0;
    mode_of(7, m);
    check("R8 evict wins over accept", m, 0);
    check("R8 request cleared", reloc_valid, 0);
    step();
    check("R8 no re-request after evict", reloc_valid, 0);

    repeat (3) step();
    check("R9 scoreboard drained", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule